// File: doc/BRIEF.md
# Phase-Counter Hardwired Control Unit

This block is the control unit of a small 8-bit accumulator processor. Instead of an encoded state register, it uses a phase counter whose value is decoded into one-hot phase lines, each active for exactly one clock. A separate decoder turns the instruction register contents into one line per mnemonic. Every control output is a sum of products of a phase line and instruction lines, qualified by the zero flag where a conditional jump needs it. The datapath (PC, HL, accumulator, TEMP, register bank, ALU, memory) lives outside the block and obeys the control outputs.

When an instruction reaches its last phase, the counter returns to phase 0 on the next clock. Short instructions therefore do not sit through idle phases: a register or immediate ALU instruction takes four clocks, while a load, a store or a taken jump takes five. A conditional jump that is not taken, and any undefined opcode, takes two. All pins are plain control and status signals with no handshake. The opcode input is the instruction register, and the flag input is the datapath's zero flag. Both must stay steady for the whole instruction once phase 0 has loaded them.

Top module: `phase_ctl_unit`

## Requirements
- R1: `phase_oh` is one-hot in every cycle. An asynchronous active-low reset forces phase 0 (`phase_oh` = 5'b00001) at once and holds it there.
- R2: The phase advances by one per clock until the instruction's last phase and then returns to phase 0. Lengths are: register or immediate ALU instruction 4, LDA (70h), STA (71h), JMP (74h) and JZ (72h) with zero flag 1 each 5, JZ with zero flag 0 and undefined opcodes 2.
- R3: In phase 0, for any opcode, the outputs are `ir_load`, `mem_rd`, `pc_load`, `addr_sel`=00 (PC) and `pc_src`=00 (increment).
- R4: In phase 2, a register ALU instruction drives `reg_drive`, `temp_load` and `reg_sel`=opcode[1:0]. The register opcodes are 30h-33h add, 18h-1Bh subtract, 20h-23h and, 24h-27h or. An immediate ALU instruction drives `temp_load`, `mem_rd` and `pc_load` with the PC address and increment. The immediate opcodes are 35h add, 36h subtract, 68h and, 69h or.
- R5: In phase 3, any ALU instruction drives `alu_drive`, `acc_load` and `flag_load`, with `alu_op` 000 add, 001 subtract, 010 and, 011 or.
- R6: For LDA, STA, JMP and taken JZ, phase 2 drives `hl_lo_load` and phase 3 drives `hl_hi_load`. Both phases also drive `mem_rd` and `pc_load` with the PC address and increment.
- R7: In phase 4, `addr_sel`=10 (HL). LDA drives `mem_rd` and `acc_load`. STA drives `mem_wr` and `acc_drive`. JMP and taken JZ drive `pc_load` with `pc_src`=01 (HL+1).
- R8: JZ with zero flag 0 drives `pc_load` with `pc_src`=10 (skip two bytes) in phase 1. The zero flag changes no output for any other opcode.
- R9: `mem_wr` is asserted only in phase 4 of STA, and never together with `mem_rd`.
- R10: An undefined opcode produces nothing beyond the phase-0 fetch and ends after phase 1.
- R11: Every output field not asserted by R3-R10 is zero, including `reg_sel`, `alu_op`, `pc_src` and `addr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 8 | Instruction register contents |
| zero_flag | input | 1 | Zero flag from the datapath |
| phase_oh | output | 5 | One-hot phase lines |
| ir_load | output | 1 | Load the instruction register from the data bus |
| pc_load | output | 1 | Load the PC from its source |
| pc_src | output | 2 | PC source: 00 increment, 01 HL+1, 10 skip two |
| addr_sel | output | 2 | Address mux: 00 PC, 10 HL |
| mem_rd | output | 1 | Memory read onto the data bus |
| mem_wr | output | 1 | Memory write from the data bus |
| hl_lo_load | output | 1 | Load the low byte of HL |
| hl_hi_load | output | 1 | Load the high byte of HL |
| acc_load | output | 1 | Load the accumulator from the data bus |
| acc_drive | output | 1 | Accumulator drives the data bus |
| temp_load | output | 1 | Load TEMP from the data bus |
| reg_drive | output | 1 | Selected bank register drives the data bus |
| reg_sel | output | 2 | Bank register select |
| alu_drive | output | 1 | ALU result drives the data bus |
| alu_op | output | 3 | ALU operation code |
| flag_load | output | 1 | Load the status flags |

## Verification
A phase counter that skips, sticks or fails to restart shows up at once in `phase_oh`. It also shows up in the very next cycle as a control word belonging to the wrong phase, for example a missing fetch strobe or a spurious write. A decode slip shows up as a wrong control word in the first phase where the instruction's class matters, which is phase 1 or phase 2. The bench therefore sweeps all 256 opcodes with both zero-flag values and compares the whole control word and the phase lines in every cycle of every instruction. An asynchronous reset in the middle of an instruction is also exercised.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int NUM_PHASES = 5;
  localparam int NUM_LINES  = 12;

  // instruction line indices
  localparam int IX_ADD  = 0;
  localparam int IX_SUB  = 1;
  localparam int IX_AND  = 2;
  localparam int IX_OR   = 3;
  localparam int IX_ADDI = 4;
  localparam int IX_SUBI = 5;
  localparam int IX_ANDI = 6;
  localparam int IX_ORI  = 7;
  localparam int IX_LOAD = 8;
  localparam int IX_STOR = 9;
  localparam int IX_JUMP = 10;
  localparam int IX_JZER = 11;

  // register ALU groups: opcode[7:2]
  localparam logic [5:0] GRP_ADD = 6'h0C;
  localparam logic [5:0] GRP_SUB = 6'h06;
  localparam logic [5:0] GRP_AND = 6'h08;
  localparam logic [5:0] GRP_OR  = 6'h09;

  localparam logic [7:0] OPC_ADDI = 8'h35;
  localparam logic [7:0] OPC_SUBI = 8'h36;
  localparam logic [7:0] OPC_ANDI = 8'h68;
  localparam logic [7:0] OPC_ORI  = 8'h69;
  localparam logic [7:0] OPC_LOAD = 8'h70;
  localparam logic [7:0] OPC_STOR = 8'h71;
  localparam logic [7:0] OPC_JZER = 8'h72;
  localparam logic [7:0] OPC_JUMP = 8'h74;

  localparam logic [2:0] ALU_ADD = 3'd0;
  localparam logic [2:0] ALU_SUB = 3'd1;
  localparam logic [2:0] ALU_AND = 3'd2;
  localparam logic [2:0] ALU_OR  = 3'd3;

  localparam logic [1:0] PCS_INC   = 2'd0;
  localparam logic [1:0] PCS_HL1   = 2'd1;
  localparam logic [1:0] PCS_SKIP2 = 2'd2;

  localparam logic [1:0] AS_PC = 2'd0;
  localparam logic [1:0] AS_HL = 2'd2;

  typedef struct packed {
    logic       ir_load;
    logic       pc_load;
    logic [1:0] pc_src;
    logic [1:0] addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       hl_lo_load;
    logic       hl_hi_load;
    logic       acc_load;
    logic       acc_drive;
    logic       temp_load;
    logic       reg_drive;
    logic [1:0] reg_sel;
    logic       alu_drive;
    logic [2:0] alu_op;
    logic       flag_load;
  } ctl_t;
endpackage

// File: rtl/pcu_phase_counter.sv
module pcu_phase_counter #(
  parameter int K = pcu_pkg::NUM_PHASES,
  localparam int W = (K > 1) ? $clog2(K) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LAST = W'(K - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         count <= '0;
    else if (restart || count == LAST)  count <= '0;
    else                                count <= count + W'(1);
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && count != LAST) |=> count == $past(count) + W'(1)); // R2
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == '0); // R2
endmodule

// File: rtl/pcu_phase_decoder.sv
module pcu_phase_decoder #(
  parameter int K = pcu_pkg::NUM_PHASES,
  localparam int W = (K > 1) ? $clog2(K) : 1
) (
  input  logic [W-1:0] count,
  output logic [K-1:0] phase_oh
);
  for (genvar i = 0; i < K; i++) begin : g_phase
    assign phase_oh[i] = (count == W'(i));
  end
endmodule

// File: rtl/pcu_instr_decoder.sv
module pcu_instr_decoder
  import pcu_pkg::*;
(
  input  logic [7:0]           opcode,
  output logic [NUM_LINES-1:0] lines
);
  always_comb begin
    lines          = '0;
    lines[IX_ADD]  = (opcode[7:2] == GRP_ADD);
    lines[IX_SUB]  = (opcode[7:2] == GRP_SUB);
    lines[IX_AND]  = (opcode[7:2] == GRP_AND);
    lines[IX_OR]   = (opcode[7:2] == GRP_OR);
    lines[IX_ADDI] = (opcode == OPC_ADDI);
    lines[IX_SUBI] = (opcode == OPC_SUBI);
    lines[IX_ANDI] = (opcode == OPC_ANDI);
    lines[IX_ORI]  = (opcode == OPC_ORI);
    lines[IX_LOAD] = (opcode == OPC_LOAD);
    lines[IX_STOR] = (opcode == OPC_STOR);
    lines[IX_JUMP] = (opcode == OPC_JUMP);
    lines[IX_JZER] = (opcode == OPC_JZER);
  end
endmodule

// File: rtl/pcu_control_matrix.sv
module pcu_control_matrix
  import pcu_pkg::*;
#(
  parameter int K = NUM_PHASES
) (
  input  logic [K-1:0]         ph,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [1:0]           reg_bits,
  input  logic                 zero_flag,
  output ctl_t                 ctl,
  output logic                 last
);
  logic alu_reg, alu_imm, alu_any, addr_ins, jmp_any, jz_skip, undef;
  logic p0, p1, p2, p3, p4;

  assign p0 = ph[0];
  assign p1 = ph[1];
  assign p2 = ph[2];
  assign p3 = ph[3];
  assign p4 = ph[4];

  assign alu_reg  = lines[IX_ADD] | lines[IX_SUB] | lines[IX_AND] | lines[IX_OR];
  assign alu_imm  = lines[IX_ADDI] | lines[IX_SUBI] | lines[IX_ANDI] | lines[IX_ORI];
  assign alu_any  = alu_reg | alu_imm;
  // a JZ that reaches phase 2 is always a taken one
  assign jmp_any  = lines[IX_JUMP] | lines[IX_JZER];
  assign addr_ins = lines[IX_LOAD] | lines[IX_STOR] | jmp_any;
  assign jz_skip  = lines[IX_JZER] & ~zero_flag;
  assign undef    = ~|lines;

  always_comb begin
    ctl            = '0;
    ctl.ir_load    = p0;
    ctl.mem_rd     = p0 | (p2 & (alu_imm | addr_ins)) | (p3 & addr_ins)
                   | (p4 & lines[IX_LOAD]);
    ctl.mem_wr     = p4 & lines[IX_STOR];
    ctl.pc_load    = p0 | (p1 & jz_skip) | (p2 & (alu_imm | addr_ins))
                   | (p3 & addr_ins) | (p4 & jmp_any);
    if (p1 & jz_skip)      ctl.pc_src = PCS_SKIP2;
    else if (p4 & jmp_any) ctl.pc_src = PCS_HL1;
    else                   ctl.pc_src = PCS_INC;
    ctl.addr_sel   = (p4 & addr_ins) ? AS_HL : AS_PC;
    ctl.hl_lo_load = p2 & addr_ins;
    ctl.hl_hi_load = p3 & addr_ins;
    ctl.acc_load   = (p3 & alu_any) | (p4 & lines[IX_LOAD]);
    ctl.acc_drive  = p4 & lines[IX_STOR];
    ctl.temp_load  = p2 & alu_any;
    ctl.reg_drive  = p2 & alu_reg;
    ctl.reg_sel    = (p2 & alu_reg) ? reg_bits : 2'b00;
    ctl.alu_drive  = p3 & alu_any;
    ctl.flag_load  = p3 & alu_any;
    ctl.alu_op[2]  = 1'b0;
    ctl.alu_op[1]  = p3 & (lines[IX_AND] | lines[IX_ANDI] | lines[IX_OR] | lines[IX_ORI]);
    ctl.alu_op[0]  = p3 & (lines[IX_SUB] | lines[IX_SUBI] | lines[IX_OR] | lines[IX_ORI]);
  end

  assign last = (p1 & (jz_skip | undef)) | (p3 & alu_any) | (p4 & addr_ins);
endmodule

// File: rtl/phase_ctl_unit.sv
module phase_ctl_unit
  import pcu_pkg::*;
#(
  parameter int NUM_PH = NUM_PHASES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        opcode,
  input  logic              zero_flag,
  output logic [NUM_PH-1:0] phase_oh,
  output logic              ir_load,
  output logic              pc_load,
  output logic [1:0]        pc_src,
  output logic [1:0]        addr_sel,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              hl_lo_load,
  output logic              hl_hi_load,
  output logic              acc_load,
  output logic              acc_drive,
  output logic              temp_load,
  output logic              reg_drive,
  output logic [1:0]        reg_sel,
  output logic              alu_drive,
  output logic [2:0]        alu_op,
  output logic              flag_load
);
  localparam int CW = (NUM_PH > 1) ? $clog2(NUM_PH) : 1;

  logic [CW-1:0]        count;
  logic [NUM_LINES-1:0] lines;
  logic                 last;
  ctl_t                 ctl;

  pcu_phase_counter #(.K(NUM_PH)) u_count (
    .clk(clk), .rst_n(rst_n), .restart(last), .count(count)
  );

  pcu_phase_decoder #(.K(NUM_PH)) u_phdec (
    .count(count), .phase_oh(phase_oh)
  );

  pcu_instr_decoder u_idec (
    .opcode(opcode), .lines(lines)
  );

  pcu_control_matrix #(.K(NUM_PH)) u_matrix (
    .ph(phase_oh), .lines(lines), .reg_bits(opcode[1:0]),
    .zero_flag(zero_flag), .ctl(ctl), .last(last)
  );

  assign ir_load    = ctl.ir_load;
  assign pc_load    = ctl.pc_load;
  assign pc_src     = ctl.pc_src;
  assign addr_sel   = ctl.addr_sel;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign hl_lo_load = ctl.hl_lo_load;
  assign hl_hi_load = ctl.hl_hi_load;
  assign acc_load   = ctl.acc_load;
  assign acc_drive  = ctl.acc_drive;
  assign temp_load  = ctl.temp_load;
  assign reg_drive  = ctl.reg_drive;
  assign reg_sel    = ctl.reg_sel;
  assign alu_drive  = ctl.alu_drive;
  assign alu_op     = ctl.alu_op;
  assign flag_load  = ctl.flag_load;

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(phase_oh)); // R1
  AST_FETCH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[0] |-> (ir_load && mem_rd && pc_load && addr_sel == AS_PC && pc_src == PCS_INC)); // R3
  AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (opcode == OPC_STOR && phase_oh[4])); // R9
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R9
  AST_DECODE_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lines)); // R10
  AST_UNDEF_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh[1] && lines == '0) |=> phase_oh[0]); // R10
  AST_JZ_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh[1] && opcode == OPC_JZER && !zero_flag) |-> (pc_load && pc_src == PCS_SKIP2)); // R8
endmodule

// File: tb/phase_ctl_unit_bench.sv
module phase_ctl_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] opcode;
  logic       zero_flag;
  logic [4:0] phase_oh;
  logic       ir_load, pc_load, mem_rd, mem_wr, hl_lo_load, hl_hi_load;
  logic       acc_load, acc_drive, temp_load, reg_drive, alu_drive, flag_load;
  logic [1:0] pc_src, addr_sel, reg_sel;
  logic [2:0] alu_op;
  logic [20:0] dut_vec;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  phase_ctl_unit u_phase_ctl_unit (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .zero_flag(zero_flag),
    .phase_oh(phase_oh), .ir_load(ir_load), .pc_load(pc_load), .pc_src(pc_src),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .hl_lo_load(hl_lo_load), .hl_hi_load(hl_hi_load), .acc_load(acc_load),
    .acc_drive(acc_drive), .temp_load(temp_load), .reg_drive(reg_drive),
    .reg_sel(reg_sel), .alu_drive(alu_drive), .alu_op(alu_op), .flag_load(flag_load)
  );

  assign dut_vec = {ir_load, pc_load, pc_src, addr_sel, mem_rd, mem_wr, hl_lo_load,
                    hl_hi_load, acc_load, acc_drive, temp_load, reg_drive, reg_sel,
                    alu_drive, alu_op, flag_load};

  function automatic bit is_reg(input logic [7:0] op);
    return (op >= 8'h30 && op <= 8'h33) || (op >= 8'h18 && op <= 8'h1B) ||
           (op >= 8'h20 && op <= 8'h27);
  endfunction
  function automatic bit is_imm(input logic [7:0] op);
    return op == 8'h35 || op == 8'h36 || op == 8'h68 || op == 8'h69;
  endfunction
  function automatic bit is_adr(input logic [7:0] op, input logic z);
    return op == 8'h70 || op == 8'h71 || op == 8'h74 || (op == 8'h72 && z);
  endfunction
  function automatic logic [2:0] alu_code(input logic [7:0] op);
    if ((op >= 8'h18 && op <= 8'h1B) || op == 8'h36) return 3'd1;
    if ((op >= 8'h20 && op <= 8'h23) || op == 8'h68) return 3'd2;
    if ((op >= 8'h24 && op <= 8'h27) || op == 8'h69) return 3'd3;
    return 3'd0;
  endfunction
  function automatic int exp_len(input logic [7:0] op, input logic z);
    if (is_reg(op) || is_imm(op)) return 4;
    if (is_adr(op, z)) return 5;
    return 2;
  endfunction

  function automatic logic [20:0] exp_vec(input logic [7:0] op, input logic z, input int ph);
    logic ir = 0, pcl = 0, rd = 0, wr = 0, hlo = 0, hhi = 0, accl = 0, accd = 0;
    logic tmp = 0, rdrv = 0, adrv = 0, fl = 0;
    logic [1:0] pcs = 0, asel = 0, rs = 0;
    logic [2:0] aop = 0;
    bit alu = is_reg(op) || is_imm(op);
    case (ph)
      0: begin ir = 1; rd = 1; pcl = 1; end
      1: if (op == 8'h72 && !z) begin pcl = 1; pcs = 2'd2; end
      2: begin
        if (is_reg(op)) begin rdrv = 1; tmp = 1; rs = op[1:0]; end
        if (is_imm(op)) begin tmp = 1; rd = 1; pcl = 1; end
        if (is_adr(op, z)) begin hlo = 1; rd = 1; pcl = 1; end
      end
      3: begin
        if (alu) begin adrv = 1; accl = 1; fl = 1; aop = alu_code(op); end
        if (is_adr(op, z)) begin hhi = 1; rd = 1; pcl = 1; end
      end
      4: begin
        asel = 2'd2;
        if (op == 8'h70) begin rd = 1; accl = 1; end
        if (op == 8'h71) begin wr = 1; accd = 1; end
        if (op == 8'h74 || op == 8'h72) begin pcl = 1; pcs = 2'd1; end
      end
      default: ;
    endcase
    return {ir, pcl, pcs, asel, rd, wr, hlo, hhi, accl, accd, tmp, rdrv, rs, adrv, aop, fl};
  endfunction

  function automatic string tag_for(input logic [7:0] op, input logic z, input int ph);
    if (ph == 0) return "R3";
    if (op == 8'h72 && !z) return "R8";
    if (!is_reg(op) && !is_imm(op) && !is_adr(op, z)) return "R10";
    if (ph == 4) return "R7";
    if (is_adr(op, z)) return "R6";
    if (ph == 2) return "R4";
    if (ph == 3) return "R5";
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input logic [7:0] op, input logic z);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%02h z=%0d got=%h expected=%h", tag, op, z, got, exp);
    end
  endtask

  // at a negedge on entry and on exit
  task automatic run_instr(input logic [7:0] op, input logic z);
    int n = exp_len(op, z);
    opcode = op;
    zero_flag = z;
    for (int p = 0; p < n; p++) begin
      #2;
      check("R2", 32'(phase_oh), 32'(1) << p, op, z);
      check(tag_for(op, z, p), 32'(dut_vec), 32'(exp_vec(op, z, p)), op, z);
      check("R9", 32'(mem_wr), 32'(op == 8'h71 && p == 4), op, z);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    opcode = 8'h70;
    zero_flag = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    check("R1", 32'(phase_oh), 32'd1, opcode, zero_flag);
    check("R3", 32'(dut_vec), 32'(exp_vec(8'h70, 1'b1, 0)), opcode, zero_flag);
    @(negedge clk);
    rst_n = 1'b1;
    for (int o = 0; o < 256; o++)
      for (int zz = 0; zz < 2; zz++)
        run_instr(8'(o), zz[0]);
    // asynchronous reset in phase 3 of a load
    opcode = 8'h70;
    zero_flag = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check("R2", 32'(phase_oh), 32'd8, opcode, zero_flag);
    rst_n = 1'b0;
    #1;
    check("R1", 32'(phase_oh), 32'd1, opcode, zero_flag);
    @(negedge clk);
    rst_n = 1'b1;
    run_instr(8'h25, 1'b0);
    run_instr(8'h71, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule